// File: doc/BRIEF.md
# Four-port APB GPIO controller with port A interrupts

The block is a 32-bit APB slave that serves four general-purpose I/O ports (A, B, C and D). The pin count of each port is set by a parameter. Each port has an output value register and a direction register, and software can also read the pins' own levels through a separate synchronised view. Register reads are answered in the access cycle with no wait states. Writes take effect on the clock edge that ends the APB access phase.

Only port A can raise interrupts. Software chooses for each port A pin whether it is edge- or level-sensitive and which polarity counts as active. Each pin also has its own enable and mask bits. Edges are held in a latch until software clears them by writing ones to the clear register. Level conditions are not latched and follow the pin. All unmasked, enabled conditions are ORed onto a single interrupt line.

Top module: `gpio_apb_ctrl`

## Requirements
- R1: While rst_ni is low, every register is zero. All pin outputs, all direction outputs and irq_o are zero, and every register reads back as zero.
- R2: The output value and direction registers of port p (p = 0..3 for A..D) are at byte offsets 0x0c*p and 0x0c*p+4. Only the low W(p) bits are stored and read back, and the upper bits read as zero. The stored values drive the port's pin and direction outputs, and a 1 in a direction bit marks that pin as an output. A register holds its value when it is not written.
- R3: The pin levels of port p are read at offset 0x50+4*p. The value read reflects a pin change after two clock edges: it still shows the old level one edge after the change.
- R4: The port A interrupt registers are enable at 0x30, mask at 0x34, type at 0x38 and polarity at 0x3c. With type bit 1 (edge) and polarity 1, a rising edge of the synchronised pin is latched. With polarity 0, a falling edge is latched. The opposite edge latches nothing. A latched edge appears in irq_o three clock edges after the pin changes.
- R5: With type bit 0 (level), the status bit follows the synchronised pin. It is set for a high pin when polarity is 1 and for a low pin when polarity is 0, and it is visible two clock edges after the pin changes. A level condition is never latched and is not affected by the clear register.
- R6: A pin whose enable bit is 0 latches no edge and shows no status. Clearing the enable bit also discards any edge already latched for that pin.
- R7: A mask bit of 1 removes the pin from the status register (0x40) and from irq_o, but it does not stop the edge from being latched. Clearing the mask bit reveals the held edge.
- R8: Writing the clear register at 0x4c clears the latched edge of each pin whose data bit is 1. Pins whose data bit is 0 keep their latch.
- R9: irq_o is 1 exactly when the status register is non-zero.
- R10: Offsets that are not mapped read as zero, and writes to them change no register. The status register ignores writes, and the clear register reads as zero.
- R11: Pin activity on ports B, C and D never sets a status bit or irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write when 1 |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| port_a_i | input | WA | Port A pin levels |
| port_a_o | output | WA | Port A output values |
| port_a_oe_o | output | WA | Port A directions (1 = output) |
| port_b_i | input | WB | Port B pin levels |
| port_b_o | output | WB | Port B output values |
| port_b_oe_o | output | WB | Port B directions |
| port_c_i | input | WC | Port C pin levels |
| port_c_o | output | WC | Port C output values |
| port_c_oe_o | output | WC | Port C directions |
| port_d_i | input | WD | Port D pin levels |
| port_d_o | output | WD | Port D output values |
| port_d_oe_o | output | WD | Port D directions |
| irq_o | output | 1 | Combined port A interrupt |

## Verification
Register writes are visible at the read port, and at the pin and direction outputs, from the negative edge that follows the completing write edge. The bench samples them there. Pin reads and level status are due two edges after a pin change, and latched edges are due three edges after it. The bench changes pins on a negative edge and checks irq_o on the negative edges one before and exactly on the cycle the result is due, so an extra or missing pipeline stage is caught. Clear, mask and enable effects are read back through the status register on the negative edge after the write.

// File: rtl/gpio_apb_pkg.sv
package gpio_apb_pkg;
  // word indices (byte offset / 4)
  localparam int unsigned PORT_STRIDE_W = 3;
  localparam int unsigned IDX_EN        = 12;
  localparam int unsigned IDX_MASK      = 13;
  localparam int unsigned IDX_TYPE      = 14;
  localparam int unsigned IDX_POL       = 15;
  localparam int unsigned IDX_STAT      = 16;
  localparam int unsigned IDX_EOI       = 19;
  localparam int unsigned IDX_EXT0      = 20;
  localparam int unsigned NUM_PORTS     = 4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dat_we_i,
  input  logic         dir_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dat_o,
  output logic [W-1:0] dir_o
);
  logic [W-1:0] dat_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q <= '0;
      dir_q <= '0;
    end else begin
      if (dat_we_i) dat_q <= wdata_i;
      if (dir_we_i) dir_q <= wdata_i;
    end
  end

  assign dat_o = dat_q;
  assign dir_o = dir_q;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_we_i,
  input  logic         mask_we_i,
  input  logic         type_we_i,
  input  logic         pol_we_i,
  input  logic         eoi_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pin_s_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] type_o,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] latch_o,
  output logic [W-1:0] pin_d_o,
  output logic [W-1:0] status_o,
  output logic         irq_o
);
  logic [W-1:0] en_q, mask_q, type_q, pol_q, latch_q, pin_d_q;
  logic [W-1:0] rise, fall, edge_hit, clr, level_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mask_q <= '0;
      type_q <= '0;
      pol_q  <= '0;
    end else begin
      if (en_we_i)   en_q   <= wdata_i;
      if (mask_we_i) mask_q <= wdata_i;
      if (type_we_i) type_q <= wdata_i;
      if (pol_we_i)  pol_q  <= wdata_i;
    end
  end

  assign rise     = pin_s_i & ~pin_d_q;
  assign fall     = ~pin_s_i & pin_d_q;
  assign edge_hit = type_q & en_q & ((pol_q & rise) | (~pol_q & fall));
  assign clr      = eoi_we_i ? wdata_i : '0;

  // a new edge wins over a clear in the same cycle; disable drops the latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_d_q <= '0;
      latch_q <= '0;
    end else begin
      pin_d_q <= pin_s_i;
      latch_q <= ((latch_q & ~clr) | edge_hit) & en_q;
    end
  end

  assign level_act = ~type_q & ~(pin_s_i ^ pol_q);
  assign status_o  = ((type_q & latch_q) | level_act) & en_q & ~mask_q;
  assign irq_o     = |status_o;

  assign en_o    = en_q;
  assign mask_o  = mask_q;
  assign type_o  = type_q;
  assign pol_o   = pol_q;
  assign latch_o = latch_q;
  assign pin_d_o = pin_d_q;
endmodule

// File: rtl/gpio_apb_ctrl.sv
module gpio_apb_ctrl
  import gpio_apb_pkg::*;
#(
  parameter int unsigned WA     = 8,
  parameter int unsigned WB     = 8,
  parameter int unsigned WC     = 16,
  parameter int unsigned WD     = 4,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  input  logic [WA-1:0]     port_a_i,
  output logic [WA-1:0]     port_a_o,
  output logic [WA-1:0]     port_a_oe_o,
  input  logic [WB-1:0]     port_b_i,
  output logic [WB-1:0]     port_b_o,
  output logic [WB-1:0]     port_b_oe_o,
  input  logic [WC-1:0]     port_c_i,
  output logic [WC-1:0]     port_c_o,
  output logic [WC-1:0]     port_c_oe_o,
  input  logic [WD-1:0]     port_d_i,
  output logic [WD-1:0]     port_d_o,
  output logic [WD-1:0]     port_d_oe_o,
  output logic              irq_o
);
  localparam int unsigned WAW = ADDR_W - 2;

  function automatic int unsigned port_w(int unsigned p);
    case (p)
      0:       return WA;
      1:       return WB;
      2:       return WC;
      default: return WD;
    endcase
  endfunction

  logic           wr_en;
  logic [WAW-1:0] waddr;
  int unsigned    idx;
  logic [31:0]    dat_q [NUM_PORTS];
  logic [31:0]    dir_q [NUM_PORTS];
  logic [31:0]    ext_q [NUM_PORTS];
  logic [WA-1:0]  pin_a_s, pin_a_d;
  logic [WA-1:0]  irq_en, irq_mask, irq_type, irq_pol, irq_latch, irq_status;
  logic           eoi_we;
  logic           unused_sink;

  assign wr_en = psel_i & penable_i & pwrite_i;
  assign waddr = paddr_i[ADDR_W-1:2];
  assign idx   = int'(waddr);
  assign unused_sink = ^{paddr_i[1:0], pwdata_i};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int unsigned W = port_w(p);
    logic [W-1:0] pin_raw, pin_s, dat, dir;

    if (p == 0) begin : g_a
      assign pin_raw = port_a_i;
      assign pin_a_s = pin_s;
    end else if (p == 1) begin : g_b
      assign pin_raw = port_b_i;
    end else if (p == 2) begin : g_c
      assign pin_raw = port_c_i;
    end else begin : g_d
      assign pin_raw = port_d_i;
    end

    gpio_sync #(.W(W)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_raw),
      .q_o   (pin_s)
    );

    gpio_port_regs #(.W(W)) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .dat_we_i(wr_en && idx == p * PORT_STRIDE_W),
      .dir_we_i(wr_en && idx == p * PORT_STRIDE_W + 1),
      .wdata_i (pwdata_i[W-1:0]),
      .dat_o   (dat),
      .dir_o   (dir)
    );

    assign dat_q[p] = 32'(dat);
    assign dir_q[p] = 32'(dir);
    assign ext_q[p] = 32'(pin_s);
  end

  assign eoi_we = wr_en && idx == IDX_EOI;

  gpio_irq_unit #(.W(WA)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_we_i  (wr_en && idx == IDX_EN),
    .mask_we_i(wr_en && idx == IDX_MASK),
    .type_we_i(wr_en && idx == IDX_TYPE),
    .pol_we_i (wr_en && idx == IDX_POL),
    .eoi_we_i (eoi_we),
    .wdata_i  (pwdata_i[WA-1:0]),
    .pin_s_i  (pin_a_s),
    .en_o     (irq_en),
    .mask_o   (irq_mask),
    .type_o   (irq_type),
    .pol_o    (irq_pol),
    .latch_o  (irq_latch),
    .pin_d_o  (pin_a_d),
    .status_o (irq_status),
    .irq_o    (irq_o)
  );

  always_comb begin
    prdata_o = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (idx == p * PORT_STRIDE_W)     prdata_o = dat_q[p];
      if (idx == p * PORT_STRIDE_W + 1) prdata_o = dir_q[p];
      if (idx == IDX_EXT0 + p)          prdata_o = ext_q[p];
    end
    case (idx)
      IDX_EN:   prdata_o = 32'(irq_en);
      IDX_MASK: prdata_o = 32'(irq_mask);
      IDX_TYPE: prdata_o = 32'(irq_type);
      IDX_POL:  prdata_o = 32'(irq_pol);
      IDX_STAT: prdata_o = 32'(irq_status);
      default:  ;
    endcase
  end

  assign port_a_o    = dat_q[0][WA-1:0];
  assign port_a_oe_o = dir_q[0][WA-1:0];
  assign port_b_o    = dat_q[1][WB-1:0];
  assign port_b_oe_o = dir_q[1][WB-1:0];
  assign port_c_o    = dat_q[2][WC-1:0];
  assign port_c_oe_o = dir_q[2][WC-1:0];
  assign port_d_o    = dat_q[3][WD-1:0];
  assign port_d_oe_o = dir_q[3][WD-1:0];
endmodule

// File: rtl/gpio_apb_ctrl_chk.sv
module gpio_apb_ctrl_chk #(
  parameter int unsigned WA = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en,
  input logic          eoi_we,
  input logic [WA-1:0] wdata,
  input logic [WA-1:0] port_a_o,
  input logic          irq_o,
  input logic [WA-1:0] en,
  input logic [WA-1:0] latch,
  input logic [WA-1:0] pin_s,
  input logic [WA-1:0] pin_d
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (irq_o == 1'b0 && port_a_o == '0)
        else $error("irq or port A output active in reset");
    end
  end

  a_r2_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(port_a_o));

  a_r4_latch_needs_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (latch & ~$past(latch) & ~$past(pin_s ^ pin_d)) == '0);

  a_r6_disabled_no_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (latch & ~$past(en)) == '0);

  a_r8_clear_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_we |=> ($past(latch) & ~$past(wdata) & $past(en) & ~latch) == '0);

  a_r8_clear_one_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_we |=> (latch & $past(wdata) & ~$past(pin_s ^ pin_d)) == '0);
endmodule

bind gpio_apb_ctrl gpio_apb_ctrl_chk #(.WA(WA)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en   (wr_en),
  .eoi_we  (eoi_we),
  .wdata   (pwdata_i[WA-1:0]),
  .port_a_o(port_a_o),
  .irq_o   (irq_o),
  .en      (irq_en),
  .latch   (irq_latch),
  .pin_s   (pin_a_s),
  .pin_d   (pin_a_d)
);

// File: tb/gpio_apb_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_apb_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [6:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [7:0]  pa_i = '0, pa_o, pa_oe;
  logic [7:0]  pb_i = '0, pb_o, pb_oe;
  logic [15:0] pc_i = '0, pc_o, pc_oe;
  logic [3:0]  pd_i = '0, pd_o, pd_oe;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  gpio_apb_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .port_a_i(pa_i), .port_a_o(pa_o), .port_a_oe_o(pa_oe),
    .port_b_i(pb_i), .port_b_o(pb_o), .port_b_oe_o(pb_oe),
    .port_c_i(pc_i), .port_c_o(pc_o), .port_c_oe_o(pc_oe),
    .port_d_i(pd_i), .port_d_o(pd_o), .port_d_oe_o(pd_oe),
    .irq_o(irq)
  );

  typedef struct packed {
    logic [6:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{7'h00, 32'hFFFF_FFFF, 32'h0000_00FF},
    '{7'h04, 32'h0000_00A5, 32'h0000_00A5},
    '{7'h0c, 32'h1234_5678, 32'h0000_0078},
    '{7'h10, 32'hFF00_FF00, 32'h0000_0000},
    '{7'h18, 32'hDEAD_BEEF, 32'h0000_BEEF},
    '{7'h1c, 32'h0000_FFFF, 32'h0000_FFFF},
    '{7'h24, 32'hFFFF_FFFF, 32'h0000_000F},
    '{7'h28, 32'h0000_0005, 32'h0000_0005},
    '{7'h08, 32'hFFFF_FFFF, 32'h0000_0000},
    '{7'h60, 32'hFFFF_FFFF, 32'h0000_0000},
    '{7'h40, 32'h0000_00FF, 32'h0000_0000},
    '{7'h4c, 32'h0000_00FF, 32'h0000_0000},
    '{7'h38, 32'h0000_FFFF, 32'h0000_00FF},
    '{7'h3c, 32'h0000_000F, 32'h0000_000F},
    '{7'h34, 32'h0000_00AA, 32'h0000_00AA}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apb_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    #1 d = prdata;
    psel = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    wait_n(4);
    check("R1 irq in reset", {31'd0, irq}, 32'd0);
    check("R1 port A oe in reset", {24'd0, pa_oe}, 32'd0);
    rst_ni = 1'b1;
    apb_read(7'h00, rd); check("R1 port A data reset", rd, 32'd0);
    apb_read(7'h30, rd); check("R1 enable reset", rd, 32'd0);
    apb_read(7'h40, rd); check("R1 status reset", rd, 32'd0);

    // register vectors: R2 port registers, R10 unmapped/read-only
    for (int i = 0; i < NV; i++) begin
      apb_write(VEC[i].addr, VEC[i].wdata);
      apb_read(VEC[i].addr, rd);
      check($sformatf("R2/R10 vec %0d addr %h", i, VEC[i].addr), rd, VEC[i].exp);
    end
    check("R2 port A out", {24'd0, pa_o}, 32'hFF);
    check("R2 port A dir", {24'd0, pa_oe}, 32'hA5);
    check("R2 port C out", {16'd0, pc_o}, 32'hBEEF);
    check("R2 port D dir", {28'd0, pd_oe}, 32'h5);
    apb_read(7'h04, rd); check("R10 unmapped write left A dir", rd, 32'hA5);

    // mid-run reset
    @(negedge clk); rst_ni = 1'b0;
    #1 check("R1 async reset port A out", {24'd0, pa_o}, 32'd0);
    wait_n(2); rst_ni = 1'b1;
    apb_read(7'h38, rd); check("R1 type cleared", rd, 32'd0);
    apb_read(7'h34, rd); check("R1 mask cleared", rd, 32'd0);

    // R3 pin read timing, port B
    @(negedge clk); pb_i = 8'h3C;
    apb_read(7'h54, rd); check("R3 pin B after one edge", rd, 32'd0);
    apb_read(7'h54, rd); check("R3 pin B after two edges", rd, 32'h3C);
    apb_read(7'h0c, rd); check("R3 port B data untouched", rd, 32'd0);

    // interrupt config: bit0 rise, bit1 fall, bit2 level high, bit3 level low
    pa_i = 8'h08;
    apb_write(7'h38, 32'h03);
    apb_write(7'h3c, 32'h05);
    apb_write(7'h30, 32'h0F);
    wait_n(3);
    apb_read(7'h40, rd); check("R5 idle status", rd, 32'd0);

    // R4 rising edge timing
    @(negedge clk); pa_i[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); check("R4 rise not yet at edge 2", {31'd0, irq}, 32'd0);
    @(negedge clk); check("R4 rise due at edge 3", {31'd0, irq}, 32'd1);
    apb_read(7'h40, rd); check("R4 rise status", rd, 32'h01);
    @(negedge clk); pa_i[0] = 1'b0;
    wait_n(4);
    apb_read(7'h40, rd); check("R4 rise latched after pin drop", rd, 32'h01);
    apb_write(7'h4c, 32'hFE);
    apb_read(7'h40, rd); check("R8 zero bits keep latch", rd, 32'h01);
    apb_write(7'h4c, 32'h01);
    apb_read(7'h40, rd); check("R8 one bit clears", rd, 32'h00);
    check("R9 irq low after clear", {31'd0, irq}, 32'd0);

    // R4 falling edge on bit1
    @(negedge clk); pa_i[1] = 1'b1;
    wait_n(4);
    apb_read(7'h40, rd); check("R4 fall pin ignores rise", rd, 32'h00);
    @(negedge clk); pa_i[1] = 1'b0;
    wait_n(4);
    apb_read(7'h40, rd); check("R4 fall latched", rd, 32'h02);
    apb_write(7'h4c, 32'h02);

    // R5 level high on bit2
    @(negedge clk); pa_i[2] = 1'b1;
    @(negedge clk); check("R5 level not yet at edge 1", {31'd0, irq}, 32'd0);
    @(negedge clk); check("R5 level due at edge 2", {31'd0, irq}, 32'd1);
    apb_write(7'h4c, 32'h04);
    apb_read(7'h40, rd); check("R5 clear ignored for level", rd, 32'h04);
    @(negedge clk); pa_i[2] = 1'b0;
    wait_n(3);
    apb_read(7'h40, rd); check("R5 level not latched", rd, 32'h00);
    // R5 active low on bit3
    @(negedge clk); pa_i[3] = 1'b0;
    wait_n(3);
    apb_read(7'h40, rd); check("R5 active-low level", rd, 32'h08);
    @(negedge clk); pa_i[3] = 1'b1;
    wait_n(3);

    // R7 mask
    apb_write(7'h34, 32'h01);
    @(negedge clk); pa_i[0] = 1'b1;
    wait_n(4);
    apb_read(7'h40, rd); check("R7 masked status", rd, 32'h00);
    check("R7 masked irq", {31'd0, irq}, 32'd0);
    apb_write(7'h34, 32'h00);
    apb_read(7'h40, rd); check("R7 unmask reveals latch", rd, 32'h01);
    apb_write(7'h4c, 32'h01);
    @(negedge clk); pa_i[0] = 1'b0;
    wait_n(3);

    // R6 enable
    apb_write(7'h30, 32'h0E);
    @(negedge clk); pa_i[0] = 1'b1;
    wait_n(4);
    apb_write(7'h30, 32'h0F);
    apb_read(7'h40, rd); check("R6 disabled edge not latched", rd, 32'h00);
    @(negedge clk); pa_i[0] = 1'b0;
    wait_n(3);
    @(negedge clk); pa_i[0] = 1'b1;
    wait_n(4);
    apb_read(7'h40, rd); check("R6 enabled edge latched", rd, 32'h01);
    apb_write(7'h30, 32'h0E);
    apb_write(7'h30, 32'h0F);
    apb_read(7'h40, rd); check("R6 disable drops latch", rd, 32'h00);

    // R9 two sources
    @(negedge clk); pa_i[2] = 1'b1; pa_i[3] = 1'b0;
    wait_n(3);
    apb_read(7'h40, rd); check("R9 two level sources", rd, 32'h0C);
    check("R9 irq high with status", {31'd0, irq}, 32'd1);
    @(negedge clk); pa_i[2] = 1'b0; pa_i[3] = 1'b1;
    wait_n(3);
    check("R9 irq low without status", {31'd0, irq}, 32'd0);

    // R11 other ports never interrupt
    @(negedge clk); pb_i = 8'hFF; pc_i = 16'hFFFF; pd_i = 4'hF;
    wait_n(2);
    @(negedge clk); pb_i = 8'h00; pc_i = 16'h0000; pd_i = 4'h0;
    wait_n(4);
    apb_read(7'h40, rd); check("R11 ports B-D no status", rd, 32'h00);
    check("R11 ports B-D no irq", {31'd0, irq}, 32'd0);

    summary();
    $finish;
  end
endmodule